// File: doc/BRIEF.md
# Clock Output Select and Shared Pin Multiplexer

This block holds one 16-bit control word, written over a simple register bus, and routes signals out of the chip according to it. Its first job is to drive a single clock-output pin. That pin is either held low or carries one internal clock, picked by a 5-bit source code. Its second job covers four shared pins, numbered 4 to 7. An external peripheral-enable mask decides, pin by pin, whether the pin carries general-purpose output data or a peripheral signal. In peripheral mode, one bit per pin in the control word picks one of two signals. A clear bit gives the quadrature-decoder signal for that pin. A set bit gives a fixed internal clock for that pin.

Clock generation, glitch-free switching between clocks and the decoder itself are outside this block. Clocks and decoder outputs arrive as plain level inputs and are routed combinationally. Nothing here streams data, so every port is a plain control or data pin with no valid/ready handshake. The write port accepts a word in any cycle.

Top module: `clkout_pinmux`

## Requirements
- R1: After reset, the read data is 0x0020. This means the clock output is disabled, the source code is 0, and all four pins use their decoder signals.
- R2: The word is stored on a rising clock edge only when `reg_sel_i` and `reg_we_i` are both high. If either is low, the stored word is unchanged.
- R3: Bits 15..10 always read as zero. Writing ones to them changes nothing that can be observed.
- R4: `reg_rdata_o` shows the stored word combinationally, in the same cycle it is stored.
- R5: When `per_en_i[k]` is 0, `pin_o[k]` equals `gpio_do_i[k]`, whatever the control word holds.
- R6: When `per_en_i[k]` is 1 and swap bit 6+k is 0, `pin_o[k]` equals `qd_i[k]`. The decoder signals are ordered as k=0 home, k=1 index, k=2 phase B, k=3 phase A.
- R7: When `per_en_i[k]` is 1 and swap bit 6+k is 1, `pin_o[k]` carries a fixed clock for that pin. Pin k=0 gets `pref_clk_i`, k=1 gets `sys_clk_i`, k=2 gets `sys_clk2_i`, and k=3 gets `osc_clk_i`.
- R8: When bit 5 (disable) is 1, `clkout_o` is 0.
- R9: When bit 5 is 0, source code 0 (bits 4..0) routes `sys_clk_i` to `clkout_o`. A code n from 1 to NUM_AUX routes `aux_clk_i[n-1]` to `clkout_o`.
- R10: When bit 5 is 0, any source code above NUM_AUX drives `clkout_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Address match for the control word |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Stored control word, reserved bits zero |
| sys_clk_i | input | 1 | System clock (source code 0, pin 5 clock) |
| sys_clk2_i | input | 1 | Secondary system clock (pin 6 clock) |
| osc_clk_i | input | 1 | Raw oscillator clock (pin 7 clock) |
| pref_clk_i | input | 1 | Prescaler reference clock (pin 4 clock) |
| aux_clk_i | input | NUM_AUX | Further clock-output sources, codes 1..NUM_AUX |
| qd_i | input | 4 | Decoder signals: home, index, phase B, phase A |
| per_en_i | input | 4 | Peripheral-enable mask for pins 4..7 |
| gpio_do_i | input | 4 | General-purpose output data for pins 4..7 |
| pin_o | output | 4 | Shared pin outputs, bit k is pin 4+k |
| clkout_o | output | 1 | Clock-output pin |

## Verification
A corrupted stored word appears on `reg_rdata_o` in the same cycle it is stored. It also appears on the routed outputs the moment the inputs can tell the candidate sources apart. A swap bit stored in the wrong position, for example, sends the wrong clock to a pin as soon as that pin's enable bit is set. The sweeps cover every swap setting with every enable mask, and every source code with the disable bit both clear and set. Each setting is driven with several input patterns, so that no source shares a level with the signal it could be confused with. A stuck or misrouted path therefore shows up within a few cycles of the setting that uses it.

// File: rtl/cosel_pkg.sv
package cosel_pkg;
  localparam int REG_W = 16;
  localparam int SEL_W = 5;
  localparam int NPIN  = 4;
  localparam logic [REG_W-1:0] RST_VAL = 16'h0020;
  localparam logic [REG_W-1:0] WR_MASK = 16'h03FF;

  typedef struct packed {
    logic [5:0]       rsvd;
    logic [NPIN-1:0]  swap;   // bit 6+k controls pin 4+k
    logic             dis;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/cosel_regfile.sv
module cosel_regfile
  import cosel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            ctrl_o
);
  ctrl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q <= ctrl_t'(RST_VAL);
    else if (sel_i && we_i) q <= ctrl_t'(wdata_i & WR_MASK);
  end

  assign ctrl_o = q;

  // R1
  reset_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ctrl_o == ctrl_t'(RST_VAL));
  // R2
  write_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i) |=> ctrl_o[9:0] == $past(wdata_i[9:0]));
  // R2
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i) |=> $stable(ctrl_o));
  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.rsvd == 6'd0);
endmodule

// File: rtl/cosel_clkout_mux.sv
module cosel_clkout_mux
  import cosel_pkg::*;
#(
  parameter int NUM_AUX = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dis_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               sys_clk_i,
  input  logic [NUM_AUX-1:0] aux_clk_i,
  output logic               clkout_o
);
  localparam int NSRC = NUM_AUX + 1;
  localparam int NCODE = 1 << SEL_W;

  logic [NSRC-1:0]  src;
  logic [NCODE-1:0] padded;

  assign src    = {aux_clk_i, sys_clk_i};
  assign padded = NCODE'(src);

  always_comb begin
    clkout_o = 1'b0;
    if (!dis_i) clkout_o = padded[sel_i];
  end

  // R8
  clkout_dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> !clkout_o);
  // R9
  clkout_sys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dis_i && sel_i == '0) |-> clkout_o == sys_clk_i);
endmodule

// File: rtl/cosel_pin_mux.sv
module cosel_pin_mux
  import cosel_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] swap_i,
  input  logic [NPIN-1:0] per_en_i,
  input  logic [NPIN-1:0] gpio_do_i,
  input  logic [NPIN-1:0] qd_i,
  input  logic [NPIN-1:0] alt_clk_i,
  output logic [NPIN-1:0] pin_o
);
  for (genvar k = 0; k < NPIN; k++) begin : g_lane
    logic periph;
    assign periph   = swap_i[k] ? alt_clk_i[k] : qd_i[k];
    assign pin_o[k] = per_en_i[k] ? periph : gpio_do_i[k];

    // R5
    gpio_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !per_en_i[k] |-> pin_o[k] == gpio_do_i[k]);
    // R6
    decoder_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_en_i[k] && !swap_i[k]) |-> pin_o[k] == qd_i[k]);
  end
endmodule

// File: rtl/clkout_pinmux.sv
module clkout_pinmux
  import cosel_pkg::*;
#(
  parameter int NUM_AUX = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_sel_i,
  input  logic               reg_we_i,
  input  logic [15:0]        reg_wdata_i,
  output logic [15:0]        reg_rdata_o,
  input  logic               sys_clk_i,
  input  logic               sys_clk2_i,
  input  logic               osc_clk_i,
  input  logic               pref_clk_i,
  input  logic [NUM_AUX-1:0] aux_clk_i,
  input  logic [3:0]         qd_i,
  input  logic [3:0]         per_en_i,
  input  logic [3:0]         gpio_do_i,
  output logic [3:0]         pin_o,
  output logic               clkout_o
);
  ctrl_t ctrl;

  cosel_regfile u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (reg_sel_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl)
  );

  assign reg_rdata_o = ctrl;

  cosel_clkout_mux #(.NUM_AUX(NUM_AUX)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dis_i     (ctrl.dis),
    .sel_i     (ctrl.sel),
    .sys_clk_i (sys_clk_i),
    .aux_clk_i (aux_clk_i),
    .clkout_o  (clkout_o)
  );

  cosel_pin_mux u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (ctrl.swap),
    .per_en_i  (per_en_i),
    .gpio_do_i (gpio_do_i),
    .qd_i      (qd_i),
    .alt_clk_i ({osc_clk_i, sys_clk2_i, sys_clk_i, pref_clk_i}),
    .pin_o     (pin_o)
  );

  // R10
  clkout_unused_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[4:0] > NUM_AUX) |-> !clkout_o);
  // R7
  pin_clock_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_en_i[3] && reg_rdata_o[9]) |-> pin_o[3] == osc_clk_i);
endmodule

// File: tb/test_clkout_pinmux.sv
`timescale 1ns/1ps
module test_clkout_pinmux;
  localparam int NA = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsel = 1'b0, rwe = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic sysc = 0, sys2 = 0, osc = 0, pref = 0;
  logic [NA-1:0] aux = '0;
  logic [3:0] qd = '0, pen = '0, gdo = '0, pins;
  logic clko;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  clkout_pinmux #(.NUM_AUX(NA)) i_clkout_pinmux (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(rsel), .reg_we_i(rwe),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sys_clk_i(sysc),
    .sys_clk2_i(sys2), .osc_clk_i(osc), .pref_clk_i(pref), .aux_clk_i(aux),
    .qd_i(qd), .per_en_i(pen), .gpio_do_i(gdo), .pin_o(pins), .clkout_o(clko));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic s, input logic w, input logic [15:0] d);
    @(negedge clk); rsel = s; rwe = w; wdata = d;
    @(negedge clk); rsel = 0; rwe = 0; wdata = 16'hDEAD;
  endtask

  function automatic logic [15:0] mix(input int p);
    return 16'((p * 40503) ^ 16'h5A3C ^ (p << 9));
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", rdata, 16'h0020);
    chk("R8 reset clkout low", {15'd0, clko}, 16'd0);

    bus(1, 1, 16'hFFFF);
    chk("R3 reserved bits ignored", rdata, 16'h03FF);
    bus(1, 0, 16'h0001);
    chk("R2 no write when we low", rdata, 16'h03FF);
    bus(0, 1, 16'h0001);
    chk("R2 no write when sel low", rdata, 16'h03FF);
    bus(1, 1, 16'hFC42);
    chk("R4 readback", rdata, 16'h0042);

    // pin sweep: every swap setting x every enable mask x patterns
    for (int sw = 0; sw < 16; sw++) begin
      bus(1, 1, 16'((sw << 6) | 16'h0020));
      chk("R2 swap write", rdata, 16'((sw << 6) | 16'h0020));
      for (int m = 0; m < 16; m++) begin
        for (int p = 0; p < 8; p++) begin
          logic [15:0] w;
          logic [3:0] ck, ex;
          w = mix(p * 16 + m);
          @(negedge clk);
          pen = 4'(m); gdo = w[3:0]; qd = w[7:4];
          pref = w[8]; sysc = w[9]; sys2 = w[10]; osc = w[11];
          #1;
          ck = {osc, sys2, sysc, pref};
          for (int k = 0; k < 4; k++)
            ex[k] = pen[k] ? (sw[k] ? ck[k] : qd[k]) : gdo[k];
          if (m == 0) chk("R5 gpio priority", {12'd0, pins}, {12'd0, ex});
          else if (sw == 0) chk("R6 decoder route", {12'd0, pins}, {12'd0, ex});
          else chk("R7 pin clock route", {12'd0, pins}, {12'd0, ex});
        end
      end
    end

    // clock-output sweep: every code, disable both ways, patterns
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 32; s++) begin
        bus(1, 1, 16'((d << 5) | s));
        for (int p = 0; p < 8; p++) begin
          logic [15:0] w;
          logic ex;
          w = mix(p + 3 * s);
          @(negedge clk);
          sysc = w[0]; aux = w[NA:1];
          #1;
          if (d == 1) ex = 1'b0;
          else if (s == 0) ex = sysc;
          else if (s <= NA) ex = aux[s-1];
          else ex = 1'b0;
          if (d == 1) chk("R8 disabled low", {15'd0, clko}, {15'd0, ex});
          else if (s <= NA) chk("R9 source route", {15'd0, clko}, {15'd0, ex});
          else chk("R10 unused code low", {15'd0, clko}, {15'd0, ex});
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule